// File: doc/BRIEF.md
# Packet DRAM Command Timing Checker

This block is a passive synchronous monitor for the command stream of a single packet-based DRAM device that has 32 banks. It watches two command channels. The row channel carries activate and precharge commands, and the column channel carries read, write and retire commands. Each channel gives a strobe, an opcode and a bank number. The monitor keeps an open or closed flag for every bank. It also keeps saturating "cycles since" timers for each bank and for the whole device. From these it decides in the same cycle whether an arriving command breaks a minimum-spacing rule.

Every command packet takes four interface cycles. The spacing limits are expressed in the same cycles and are parameters. The activate-to-column delay is set per speed grade to 7 or 9. When a command breaks a rule, `viol_o` pulses for that one cycle and `viol_code_o` names the broken rule. If several rules break at once, the lowest code wins. An offending command still updates the tracked bank state and timers, as if the device had executed it. The monitor has no effect on the traffic it observes.

Top module: `dram_cmd_timing_chk`

## Requirements
- R1: After reset all banks are closed and all timers are saturated, so the first activate, precharge or retire is legal. With no command on either channel, `viol_o` is 0 and `viol_code_o` is 0.
- R2: Two row commands of any kind closer than 4 cycles give code 1. Two column commands (read, write or retire) closer than 4 cycles give code 2.
- R3: An activate to a bank that is already open gives code 3. An activate opens its bank, and a precharge closes it.
- R4: An activate less than 28 cycles after the previous activate of the same bank gives code 4.
- R5: An activate less than 8 cycles after the previous precharge of the same bank gives code 5.
- R6: An activate less than 8 cycles after the previous activate to any bank gives code 6.
- R7: A precharge less than 20 cycles after the activate of the same bank gives code 7.
- R8: A precharge less than 8 cycles after the previous precharge to any bank gives code 8.
- R9: A precharge less than 4 cycles after the last read of the same bank gives code 9. A precharge less than 4 cycles after the last retire of the same bank gives code 10.
- R10: A read or write to a closed bank gives code 11. A retire does not need an open bank.
- R11: A read or write less than T_RCD cycles after the activate of its bank gives code 12. T_RCD defaults to 7 and may be set to 9.
- R12: A retire less than 8 cycles after the last write to the same bank gives code 13.
- R13: The flag and code appear combinationally in the cycle the command is presented. When several rules fail, the lowest code is reported. Row and column checks in one cycle use the state from before that cycle. Offending commands still update the state.
- R14: Encodings: row opcode 0 is activate and 1 is precharge. Column opcode 00 is read, 01 is write, 10 is retire, and 11 is a no-op that is ignored entirely: it raises no violation and updates no timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Interface clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| row_vld_i | input | 1 | Row command present this cycle |
| row_op_i | input | 1 | Row opcode: 0 activate, 1 precharge |
| row_bank_i | input | 5 | Row command bank |
| col_vld_i | input | 1 | Column command present this cycle |
| col_op_i | input | 2 | Column opcode: 00 read, 01 write, 10 retire, 11 no-op |
| col_bank_i | input | 5 | Column command bank |
| viol_o | output | 1 | One-cycle violation pulse |
| viol_code_o | output | 4 | Code of the lowest-numbered broken rule, 0 when none |

## Verification
The row-channel check and the column-channel check can fall in the same cycle, and their verdicts must be merged by priority. The bench presents row and column commands together in one cycle in several combinations:
- both channels legal;
- only the column command illegal;
- both channels illegal, where the row packet-spacing code must win over the closed-bank code;
- a precharge and a read to the same open bank, where the read must not count against that precharge.

Each case is judged against codes worked out from the cycle gaps.

// File: rtl/dram_chk_pkg.sv
package dram_chk_pkg;

  typedef enum logic {ROW_ACT = 1'b0, ROW_PRE = 1'b1} row_op_e;

  typedef enum logic [1:0] {
    COL_RD  = 2'b00,
    COL_WR  = 2'b01,
    COL_RET = 2'b10,
    COL_NOP = 2'b11
  } col_op_e;

  typedef enum logic [3:0] {
    V_NONE       = 4'd0,
    V_ROW_PKT    = 4'd1,
    V_COL_PKT    = 4'd2,
    V_ACT_OPEN   = 4'd3,
    V_RC         = 4'd4,
    V_RP         = 4'd5,
    V_RR         = 4'd6,
    V_RAS        = 4'd7,
    V_PP         = 4'd8,
    V_RDP        = 4'd9,
    V_RTP        = 4'd10,
    V_COL_CLOSED = 4'd11,
    V_RCD        = 4'd12,
    V_RTR        = 4'd13
  } viol_e;

  // per-bank "too soon" flags, each true while its window is still running
  typedef struct packed {
    logic open;
    logic rc;
    logic rp;
    logic ras;
    logic rdp;
    logic rtp;
    logic rcd;
    logic rtr;
  } bank_flags_t;

  typedef struct packed {
    logic row_pkt;
    logic col_pkt;
    logic rr;
    logic pp;
  } dev_flags_t;

  function automatic int max_int(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dram_chk_timer.sv
module dram_chk_timer #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         evt_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] SAT = '1;
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;

  // cycles since last event, saturating; reset reads as "long ago"
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= SAT;
    else if (evt_i)       cnt_q <= ONE;
    else if (cnt_q != SAT) cnt_q <= cnt_q + ONE;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/dram_chk_bank.sv
module dram_chk_bank
  import dram_chk_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int T_RC  = 28,
  parameter int T_RAS = 20,
  parameter int T_RP  = 8,
  parameter int T_RCD = 7,
  parameter int T_RDP = 4,
  parameter int T_RTP = 4,
  parameter int T_RTR = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        act_i,
  input  logic        pre_i,
  input  logic        rd_i,
  input  logic        wr_i,
  input  logic        ret_i,
  output bank_flags_t flags_o
);
  localparam int N_TMR = 5;
  localparam int I_ACT = 0;
  localparam int I_PRE = 1;
  localparam int I_RD  = 2;
  localparam int I_WR  = 3;
  localparam int I_RET = 4;

  localparam logic [CNT_W-1:0] L_RC  = CNT_W'(T_RC);
  localparam logic [CNT_W-1:0] L_RAS = CNT_W'(T_RAS);
  localparam logic [CNT_W-1:0] L_RP  = CNT_W'(T_RP);
  localparam logic [CNT_W-1:0] L_RCD = CNT_W'(T_RCD);
  localparam logic [CNT_W-1:0] L_RDP = CNT_W'(T_RDP);
  localparam logic [CNT_W-1:0] L_RTP = CNT_W'(T_RTP);
  localparam logic [CNT_W-1:0] L_RTR = CNT_W'(T_RTR);

  logic [N_TMR-1:0] evt;
  logic [CNT_W-1:0] cnt [N_TMR];
  logic             open_q;

  assign evt = {ret_i, wr_i, rd_i, pre_i, act_i};

  for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
    dram_chk_timer #(.W(CNT_W)) u_tmr (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .evt_i (evt[t]),
      .cnt_o (cnt[t])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    open_q <= 1'b0;
    else if (act_i) open_q <= 1'b1;
    else if (pre_i) open_q <= 1'b0;
  end

  always_comb begin
    flags_o.open = open_q;
    flags_o.rc   = cnt[I_ACT] < L_RC;
    flags_o.ras  = cnt[I_ACT] < L_RAS;
    flags_o.rcd  = cnt[I_ACT] < L_RCD;
    flags_o.rp   = cnt[I_PRE] < L_RP;
    flags_o.rdp  = cnt[I_RD]  < L_RDP;
    flags_o.rtr  = cnt[I_WR]  < L_RTR;
    flags_o.rtp  = cnt[I_RET] < L_RTP;
  end

  AST_OPEN_ON_ACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |=> open_q); // R3
  AST_SHUT_ON_PRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_i |=> !open_q); // R3

endmodule

// File: rtl/dram_chk_rules.sv
module dram_chk_rules
  import dram_chk_pkg::*;
(
  input  logic        row_act_i,
  input  logic        row_pre_i,
  input  logic        col_any_i,
  input  logic        col_rdwr_i,
  input  logic        col_ret_i,
  input  dev_flags_t  dev_i,
  input  bank_flags_t rbank_i,
  input  bank_flags_t cbank_i,
  output viol_e       code_o
);
  logic row_any;
  assign row_any = row_act_i | row_pre_i;

  // fixed priority: lowest code wins
  always_comb begin
    if      (row_any    && dev_i.row_pkt)  code_o = V_ROW_PKT;
    else if (col_any_i  && dev_i.col_pkt)  code_o = V_COL_PKT;
    else if (row_act_i  && rbank_i.open)   code_o = V_ACT_OPEN;
    else if (row_act_i  && rbank_i.rc)     code_o = V_RC;
    else if (row_act_i  && rbank_i.rp)     code_o = V_RP;
    else if (row_act_i  && dev_i.rr)       code_o = V_RR;
    else if (row_pre_i  && rbank_i.ras)    code_o = V_RAS;
    else if (row_pre_i  && dev_i.pp)       code_o = V_PP;
    else if (row_pre_i  && rbank_i.rdp)    code_o = V_RDP;
    else if (row_pre_i  && rbank_i.rtp)    code_o = V_RTP;
    else if (col_rdwr_i && !cbank_i.open)  code_o = V_COL_CLOSED;
    else if (col_rdwr_i && cbank_i.rcd)    code_o = V_RCD;
    else if (col_ret_i  && cbank_i.rtr)    code_o = V_RTR;
    else                                   code_o = V_NONE;
  end

endmodule

// File: rtl/dram_cmd_timing_chk.sv
module dram_cmd_timing_chk
  import dram_chk_pkg::*;
#(
  parameter int N_BANK = 32,
  parameter int T_PKT  = 4,
  parameter int T_CC   = 4,
  parameter int T_RC   = 28,
  parameter int T_RAS  = 20,
  parameter int T_RP   = 8,
  parameter int T_RR   = 8,
  parameter int T_PP   = 8,
  parameter int T_RCD  = 7,
  parameter int T_RDP  = 4,
  parameter int T_RTP  = 4,
  parameter int T_RTR  = 8,
  localparam int BANK_W = $clog2(N_BANK)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              row_vld_i,
  input  logic              row_op_i,
  input  logic [BANK_W-1:0] row_bank_i,
  input  logic              col_vld_i,
  input  logic [1:0]        col_op_i,
  input  logic [BANK_W-1:0] col_bank_i,
  output logic              viol_o,
  output logic [3:0]        viol_code_o
);
  localparam int TMAX = max_int(max_int(max_int(T_RC, T_RAS), max_int(T_RP, T_RR)),
                        max_int(max_int(T_PP, T_RCD), max_int(max_int(T_RDP, T_RTP),
                        max_int(T_RTR, max_int(T_PKT, T_CC)))));
  localparam int CNT_W = $clog2(TMAX + 1);
  localparam int N_DEV = 4;

  row_op_e     row_op;
  col_op_e     col_op;
  logic        row_act, row_pre;
  logic        col_v, col_rd, col_wr, col_ret, col_rdwr;
  bank_flags_t bflags [N_BANK];
  bank_flags_t rbank, cbank;
  dev_flags_t  dev;
  viol_e       code;

  assign row_op   = row_op_e'(row_op_i);
  assign col_op   = col_op_e'(col_op_i);
  assign row_act  = row_vld_i && (row_op == ROW_ACT);
  assign row_pre  = row_vld_i && (row_op == ROW_PRE);
  assign col_v    = col_vld_i && (col_op != COL_NOP);
  assign col_rd   = col_vld_i && (col_op == COL_RD);
  assign col_wr   = col_vld_i && (col_op == COL_WR);
  assign col_ret  = col_vld_i && (col_op == COL_RET);
  assign col_rdwr = col_rd | col_wr;

  // device-wide spacing timers: row pkt, col pkt, act-any, pre-any
  logic [N_DEV-1:0] dev_evt;
  logic [N_DEV-1:0] dev_soon;
  logic [CNT_W-1:0] dev_cnt [N_DEV];
  localparam int DEV_LIM [N_DEV] = '{T_PKT, T_CC, T_RR, T_PP};

  assign dev_evt = {row_pre, row_act, col_v, row_vld_i};

  for (genvar i = 0; i < N_DEV; i++) begin : g_dev
    localparam logic [CNT_W-1:0] LIM = CNT_W'(DEV_LIM[i]);
    dram_chk_timer #(.W(CNT_W)) u_tmr (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .evt_i (dev_evt[i]),
      .cnt_o (dev_cnt[i])
    );
    assign dev_soon[i] = dev_cnt[i] < LIM;
  end

  assign dev.row_pkt = dev_soon[0];
  assign dev.col_pkt = dev_soon[1];
  assign dev.rr      = dev_soon[2];
  assign dev.pp      = dev_soon[3];

  for (genvar b = 0; b < N_BANK; b++) begin : g_bank
    logic rhit, chit;
    assign rhit = row_bank_i == BANK_W'(b);
    assign chit = col_bank_i == BANK_W'(b);
    dram_chk_bank #(
      .CNT_W(CNT_W), .T_RC(T_RC), .T_RAS(T_RAS), .T_RP(T_RP), .T_RCD(T_RCD),
      .T_RDP(T_RDP), .T_RTP(T_RTP), .T_RTR(T_RTR)
    ) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .act_i  (row_act & rhit),
      .pre_i  (row_pre & rhit),
      .rd_i   (col_rd & chit),
      .wr_i   (col_wr & chit),
      .ret_i  (col_ret & chit),
      .flags_o(bflags[b])
    );
  end

  assign rbank = bflags[row_bank_i];
  assign cbank = bflags[col_bank_i];

  dram_chk_rules u_rules (
    .row_act_i (row_act),
    .row_pre_i (row_pre),
    .col_any_i (col_v),
    .col_rdwr_i(col_rdwr),
    .col_ret_i (col_ret),
    .dev_i     (dev),
    .rbank_i   (rbank),
    .cbank_i   (cbank),
    .code_o    (code)
  );

  assign viol_code_o = code;
  assign viol_o      = code != V_NONE;

  // marks that the previous cycle was already out of reset
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  AST_ROW_BACK2BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && row_vld_i && $past(row_vld_i) |-> viol_o); // R2
  AST_COL_BACK2BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && col_v && $past(col_v) |-> viol_o); // R2
  AST_ACT_ON_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_act && rbank.open |-> viol_o); // R3
  AST_COL_ON_CLOSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_rdwr && !cbank.open |-> viol_o); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !row_vld_i && !col_v |-> !viol_o && viol_code_o == 4'd0); // R1
  AST_CODE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_code_o <= 4'd13); // R13

endmodule

// File: tb/tb_dram_cmd_timing_chk.sv
`timescale 1ns/1ps
module tb_dram_cmd_timing_chk;
  localparam int ACT = 0, PRE = 1;
  localparam int RD = 0, WR = 1, RET = 2, NOP = 3;
  localparam int TRCD = 7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       row_vld = 1'b0, row_op = 1'b0;
  logic [4:0] row_bank = '0;
  logic       col_vld = 1'b0;
  logic [1:0] col_op = '0;
  logic [4:0] col_bank = '0;
  logic       viol;
  logic [3:0] code;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dram_cmd_timing_chk dut (
    .clk_i(clk), .rst_ni(rst_n),
    .row_vld_i(row_vld), .row_op_i(row_op), .row_bank_i(row_bank),
    .col_vld_i(col_vld), .col_op_i(col_op), .col_bank_i(col_bank),
    .viol_o(viol), .viol_code_o(code)
  );

  task automatic check(input int exp, input string tag);
    n_chk++;
    if (viol !== (exp != 0) || code !== 4'(exp)) begin
      n_fail++;
      $display("FAIL %s: viol=%0b code=%0d expected viol=%0b code=%0d",
               tag, viol, code, exp != 0, exp);
    end
  endtask

  task automatic clear_in;
    row_vld = 1'b0; col_vld = 1'b0; row_op = 1'b0; col_op = '0;
    row_bank = '0; col_bank = '0;
  endtask

  task automatic do_reset;
    @(negedge clk);
    clear_in();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // one command cycle on either or both channels, checked mid-cycle
  task automatic cyc(input bit rv, input int rop, input int rb,
                     input bit cv, input int cop, input int cb,
                     input int exp, input string tag);
    @(negedge clk);
    row_vld = rv; row_op = rop[0]; row_bank = 5'(rb);
    col_vld = cv; col_op = 2'(cop); col_bank = 5'(cb);
    #1 check(exp, tag);
    @(posedge clk);
    #1 clear_in();
  endtask

  task automatic row(input int op, input int b, input int exp, input string tag);
    cyc(1'b1, op, b, 1'b0, 0, 0, exp, tag);
  endtask

  task automatic col(input int op, input int b, input int exp, input string tag);
    cyc(1'b0, 0, 0, 1'b1, op, b, exp, tag);
  endtask

  // next command starts d cycles after the previous one
  task automatic gap(input int d);
    repeat (d - 1) @(negedge clk);
  endtask

  initial begin
    do_reset();
    #1 check(0, "R1 idle after reset");
    row(PRE, 4, 0, "R1 first precharge");
    do_reset();
    row(ACT, 0, 0, "R1 first activate");
    do_reset();
    col(RET, 9, 0, "R1 first retire");

    for (int d = 1; d <= 10; d++) begin
      do_reset(); row(ACT, 0, 0, "R1");
      gap(d); row(ACT, 1, d < 4 ? 1 : (d < 8 ? 6 : 0), "R2/R6 act-act other bank");
    end
    for (int d = 1; d <= 24; d++) begin
      do_reset(); row(ACT, 0, 0, "R1");
      gap(d); row(PRE, 0, d < 4 ? 1 : (d < 20 ? 7 : 0), "R7 act-pre");
    end
    for (int d = 1; d <= 10; d++) begin
      do_reset(); row(PRE, 0, 0, "R1");
      gap(d); row(PRE, 1, d < 4 ? 1 : (d < 8 ? 8 : 0), "R8 pre-pre");
    end
    for (int d = 8; d <= 18; d++) begin
      do_reset(); row(ACT, 2, 0, "R1");
      gap(12); row(PRE, 2, 7, "R13 early pre still closes");
      gap(d); row(ACT, 2, d < 16 ? 4 : 0, "R4 act-act same bank");
    end
    for (int d = 1; d <= 10; d++) begin
      do_reset(); row(ACT, 3, 0, "R1");
      gap(30); row(PRE, 3, 0, "R7");
      gap(d); row(ACT, 3, d < 4 ? 1 : (d < 8 ? 5 : 0), "R5 pre-act");
    end
    do_reset(); row(ACT, 3, 0, "R1");
    gap(40); row(ACT, 3, 3, "R3 act on open bank");
    do_reset(); row(ACT, 3, 0, "R1");
    gap(10); row(ACT, 3, 3, "R3 open beats R4 rc");

    for (int d = 1; d <= 12; d++) begin
      do_reset(); row(ACT, 6, 0, "R1");
      gap(d); col(d[0] ? RD : WR, 6, d < TRCD ? 12 : 0, "R11 act-col");
    end
    for (int d = 1; d <= 6; d++) begin
      do_reset(); row(ACT, 0, 0, "R1");
      gap(10); col(RD, 0, 0, "R11");
      gap(d); col(WR, 0, d < 4 ? 2 : 0, "R2 col-col");
    end
    for (int d = 1; d <= 10; d++) begin
      do_reset(); row(ACT, 0, 0, "R1");
      gap(10); col(WR, 0, 0, "R11");
      gap(d); col(RET, 0, d < 4 ? 2 : (d < 8 ? 13 : 0), "R12 wr-retire");
    end
    for (int d = 1; d <= 6; d++) begin
      do_reset(); row(ACT, 0, 0, "R1");
      gap(20); col(RD, 0, 0, "R11");
      gap(d); row(PRE, 0, d < 4 ? 9 : 0, "R9 rd-pre");
    end
    for (int d = 1; d <= 6; d++) begin
      do_reset(); row(ACT, 0, 0, "R1");
      gap(20); col(WR, 0, 0, "R11");
      gap(8); col(RET, 0, 0, "R12");
      gap(d); row(PRE, 0, d < 4 ? 10 : 0, "R9 retire-pre");
    end

    for (int b = 0; b < 32; b++) begin
      do_reset(); row(ACT, b, 0, "R1");
      gap(8); col(RD, b, 0, "R10 open bank read");
      gap(4); col(WR, (b + 1) % 32, 11, "R10 closed bank write");
      gap(4); col(RET, (b + 2) % 32, 0, "R10 retire to closed bank");
    end

    do_reset();
    cyc(1'b1, ACT, 1, 1'b1, RD, 1, 11, "R13 same-cycle act+rd");
    do_reset(); row(PRE, 0, 0, "R1");
    gap(2);
    cyc(1'b1, PRE, 2, 1'b1, RD, 4, 1, "R13 row pkt beats closed");
    do_reset(); row(ACT, 0, 0, "R1");
    gap(10);
    cyc(1'b1, PRE, 0, 1'b1, RD, 0, 7, "R13 ras with legal rd");
    do_reset(); row(ACT, 0, 0, "R1");
    gap(20);
    cyc(1'b1, PRE, 0, 1'b1, RD, 0, 0, "R13 same-cycle pre+rd legal");

    do_reset();
    col(NOP, 0, 0, "R14 nop to closed bank");
    row(ACT, 0, 0, "R1");
    gap(10); col(RD, 0, 0, "R11");
    gap(2);  col(NOP, 0, 0, "R14 nop ignored");
    gap(2);  col(RD, 0, 0, "R14 nop did not restart spacing");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule